// File: doc/BRIEF.md
# Acquisition Status and Interrupt Logic

This block holds the status and interrupt section of a multichannel A/D acquisition controller that sits on a byte-wide host register bus. The host reads a status byte that combines live converter state with two sticky flags. One flag records a FIFO overrun and the other records that an interrupt event occurred. The block also keeps a control byte, a small mode byte, a four-bit digital output latch and a latched external-trigger flag.

The interrupt event is taken from one of three sources. In software-trigger mode every sample written into the FIFO raises it. In paced mode the FIFO count crossing the half-full level raises it. In enhanced residual mode the terminal pulse of the residual counter raises it. Each flag is cleared by a write to its own register offset. An event that arrives in the same cycle as a clear still sets the flag.

The bus has plain strobes and no valid/ready handshake, because there is no data stream here: a write takes effect at the clock edge where `bus_wr` is high. Read data is registered, so it appears on `bus_rdata` after the edge where `bus_rd` is high and holds until the next read. The FIFO storage and the converter itself sit outside the block.

Top module: `acq_status_irq`

## Requirements
- R1: Synchronous active-high reset clears the overrun flag, the interrupt flag, the external-trigger flag, the digital outputs, the control byte, the mode byte and `bus_rdata` to 0.
- R2: A read registers the byte selected by `bus_addr` into `bus_rdata` one cycle later. The status byte is at offset 8 and holds the mux channel in bits 3:0, the interrupt flag in bit 4, the overrun flag in bit 5, unipolar/bipolar in bit 6 (1 = unipolar) and converter busy in bit 7 (1 = busy, 0 = complete). Unmapped offsets read 0.
- R3: A rising edge of `fifo_full` sets the overrun flag, and the flag then holds.
- R4: Only a write to offset 2 clears the overrun flag. If `fifo_full` stays high after the clear, the flag is not set again until `fifo_full` falls and rises again.
- R5: The interrupt flag is sticky. Any write to offset 8 clears it, but an event in the same cycle as that write sets it.
- R6: With trigger select (control bits 1:0) at 00 and residual mode off, every `fifo_wr` pulse sets the interrupt flag.
- R7: With control bit 1 set and residual mode off, the interrupt flag is set once when `fifo_count` rises from below 512 to 512 or above. A count that stays at or above 512 does not set it again, and `fifo_wr` has no effect.
- R8: With trigger select at 01 and residual mode off, no input sets the interrupt flag.
- R9: When mode byte (offset 11) bit 0 (enhanced) and bit 1 (residual enable) are both 1, only `resid_tc` sets the interrupt flag, whatever the trigger select.
- R10: `irq` is high exactly when the interrupt flag and control bit 3 (interrupt enable) are both 1.
- R11: A write to offset 3 latches `bus_wdata[3:0]` onto `dout` and clears the external-trigger flag, unless `ext_trig` pulses in the same cycle.
- R12: An `ext_trig` pulse sets `ext_trig_flag`, which holds until it is cleared as described in R11.
- R13: Writes to offset 9 and offset 11 read back as the full control byte and as the mode byte in bits 1:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| fifo_wr | input | 1 | Pulse: one sample written into the FIFO |
| fifo_full | input | 1 | FIFO full level |
| fifo_count | input | 11 | FIFO fill count |
| conv_busy | input | 1 | Converter busy |
| mux_ch | input | 4 | Channel selected for the next conversion |
| unipolar | input | 1 | Input range jumper, 1 = unipolar |
| resid_tc | input | 1 | Pulse: residual counter terminal event |
| ext_trig | input | 1 | Pulse: external trigger seen |
| dout | output | 4 | Digital output latch |
| ext_trig_flag | output | 1 | Latched external-trigger flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs every combination of trigger select, enhanced bit and residual enable against each of the three event kinds. A wrong source priority would therefore show up as a flag that sets on a foreign event or misses its own. It holds the FIFO count above the half-full level after a clear, which exposes a level detector that re-arms the flag. It also keeps `fifo_full` high across an overrun clear, which catches a level-sensitive latch. Same-cycle set and clear is driven on both sticky flags, so a design that lets the clear win loses an event. It also sweeps all 64 status input patterns and all 16 output latch values, which catches any swapped bit position.

// File: rtl/acq_stat_pkg.sv
package acq_stat_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] OFS_FIFO_CLR = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_DOUT     = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 4'd9;
  localparam logic [ADDR_W-1:0] OFS_MODE     = 4'd11;
  localparam int CTRL_IEN_BIT = 3;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_SAMPLE = 2'd1,
    SRC_HALF   = 2'd2,
    SRC_RESID  = 2'd3
  } irq_src_e;
endpackage

// File: rtl/acq_ctrl_regs.sv
module acq_ctrl_regs
  import acq_stat_pkg::*;
#(
  parameter int DOUT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ext_trig,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [1:0]        mode_q,
  output logic [DOUT_W-1:0] dout,
  output logic              ext_flag,
  output logic              clr_ovrn,
  output logic              clr_int
);
  logic wr_dout;

  assign wr_dout  = wr_en && (addr == OFS_DOUT);
  assign clr_ovrn = wr_en && (addr == OFS_FIFO_CLR);
  assign clr_int  = wr_en && (addr == OFS_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      mode_q   <= '0;
      dout     <= '0;
      ext_flag <= 1'b0;
    end else begin
      if (wr_en && addr == OFS_CTRL) ctrl_q <= wdata;
      if (wr_en && addr == OFS_MODE) mode_q <= wdata[1:0];
      if (wr_dout) dout <= wdata[DOUT_W-1:0];
      if (ext_trig)     ext_flag <= 1'b1;
      else if (wr_dout) ext_flag <= 1'b0;
    end
  end

  assert_dout_latch_R11: assert property (@(posedge clk) disable iff (rst)
    wr_dout |=> dout == $past(wdata[DOUT_W-1:0]));
  assert_ext_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_dout && !ext_trig) |=> !ext_flag);
  assert_ext_set_R12: assert property (@(posedge clk) disable iff (rst)
    ext_trig |=> ext_flag);
endmodule

// File: rtl/acq_irq_src.sv
module acq_irq_src
  import acq_stat_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int HALF_LEVEL = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       tsel,
  input  logic             enh,
  input  logic             ren,
  input  logic             ien,
  input  logic             sample_wr,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             resid_tc,
  input  logic             clr_int,
  output logic             int_flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(HALF_LEVEL);

  irq_src_e src;
  logic     half_lvl, half_q, half_evt, evt;

  assign half_lvl = (fifo_count >= HALF_CNT);
  assign half_evt = half_lvl && !half_q;

  always_comb begin
    if (enh && ren)       src = SRC_RESID;
    else if (tsel[1])     src = SRC_HALF;
    else if (tsel == 2'b00) src = SRC_SAMPLE;
    else                  src = SRC_NONE;
  end

  always_comb begin
    case (src)
      SRC_SAMPLE: evt = sample_wr;
      SRC_HALF:   evt = half_evt;
      SRC_RESID:  evt = resid_tc;
      default:    evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q   <= 1'b0;
      int_flag <= 1'b0;
    end else begin
      half_q <= half_lvl;
      if (evt)          int_flag <= 1'b1;
      else if (clr_int) int_flag <= 1'b0;
    end
  end

  assign irq = int_flag && ien;

  assert_half_single_R7: assert property (@(posedge clk) disable iff (rst)
    half_evt |=> !half_evt);
  assert_int_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_int && !evt) |=> !int_flag);
  assert_int_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (int_flag && !clr_int) |=> int_flag);
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(evt) || $rose(ien)));
endmodule

// File: rtl/acq_status_read.sv
module acq_status_read
  import acq_stat_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fifo_full,
  input  logic              clr_ovrn,
  input  logic              conv_busy,
  input  logic              unipolar,
  input  logic [CH_W-1:0]   mux_ch,
  input  logic              int_flag,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [1:0]        mode_q,
  output logic [DATA_W-1:0] rdata
);
  logic              full_q, ovrn;
  logic [DATA_W-1:0] status_byte, sel_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      ovrn   <= 1'b0;
    end else begin
      full_q <= fifo_full;
      if (fifo_full && !full_q) ovrn <= 1'b1;
      else if (clr_ovrn)        ovrn <= 1'b0;
    end
  end

  assign status_byte = {conv_busy, unipolar, ovrn, int_flag, mux_ch};

  always_comb begin
    case (addr)
      OFS_STATUS: sel_byte = status_byte;
      OFS_CTRL:   sel_byte = ctrl_q;
      OFS_MODE:   sel_byte = {{(DATA_W-2){1'b0}}, mode_q};
      default:    sel_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel_byte;
  end

  assert_ovrn_set_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_full) |=> ovrn);
  assert_ovrn_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ovrn && !clr_ovrn) |=> ovrn);
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/acq_status_irq.sv
module acq_status_irq
  import acq_stat_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int HALF_LEVEL = 512,
  parameter int CH_W       = 4,
  parameter int DOUT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fifo_wr,
  input  logic              fifo_full,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              conv_busy,
  input  logic [CH_W-1:0]   mux_ch,
  input  logic              unipolar,
  input  logic              resid_tc,
  input  logic              ext_trig,
  output logic [DOUT_W-1:0] dout,
  output logic              ext_trig_flag,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q;
  logic [1:0]        mode_q;
  logic              clr_ovrn, clr_int, int_flag;

  acq_ctrl_regs #(.DOUT_W(DOUT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ext_trig(ext_trig), .ctrl_q(ctrl_q), .mode_q(mode_q), .dout(dout),
    .ext_flag(ext_trig_flag), .clr_ovrn(clr_ovrn), .clr_int(clr_int)
  );

  acq_irq_src #(.CNT_W(CNT_W), .HALF_LEVEL(HALF_LEVEL)) u_irq (
    .clk(clk), .rst(rst), .tsel(ctrl_q[1:0]), .enh(mode_q[0]), .ren(mode_q[1]),
    .ien(ctrl_q[CTRL_IEN_BIT]), .sample_wr(fifo_wr), .fifo_count(fifo_count),
    .resid_tc(resid_tc), .clr_int(clr_int), .int_flag(int_flag), .irq(irq)
  );

  acq_status_read #(.CH_W(CH_W)) u_read (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .addr(bus_addr), .fifo_full(fifo_full),
    .clr_ovrn(clr_ovrn), .conv_busy(conv_busy), .unipolar(unipolar),
    .mux_ch(mux_ch), .int_flag(int_flag), .ctrl_q(ctrl_q), .mode_q(mode_q),
    .rdata(bus_rdata)
  );
endmodule

// File: tb/acq_status_irq_tb.sv
`timescale 1ns/1ps
module acq_status_irq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       fifo_wr = 1'b0, fifo_full = 1'b0;
  logic [10:0] fifo_count = '0;
  logic       conv_busy = 1'b0, unipolar = 1'b0, resid_tc = 1'b0, ext_trig = 1'b0;
  logic [3:0] mux_ch = '0;
  logic [3:0] dout;
  logic       ext_trig_flag, irq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  acq_status_irq u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_wr(fifo_wr),
    .fifo_full(fifo_full), .fifo_count(fifo_count), .conv_busy(conv_busy),
    .mux_ch(mux_ch), .unipolar(unipolar), .resid_tc(resid_tc),
    .ext_trig(ext_trig), .dout(dout), .ext_trig_flag(ext_trig_flag), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic half_cross();
    @(negedge clk); fifo_count = 11'd0;
    @(negedge clk); fifo_count = 11'd512;
    @(negedge clk); fifo_count = 11'd0;
  endtask

  task automatic pulse(int kind);
    @(negedge clk);
    if (kind == 1) fifo_wr = 1'b1;
    if (kind == 3) resid_tc = 1'b1;
    @(negedge clk); fifo_wr = 1'b0; resid_tc = 1'b0;
  endtask

  function automatic int exp_src(int ts, int enh, int ren);
    if (enh == 1 && ren == 1) return 3;
    if (ts >= 2) return 2;
    if (ts == 0) return 1;
    return 0;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 dout", dout, 4'h0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 ext", ext_trig_flag, 1'b0);
    rd(4'd8, rv); chk("R1 status", rv, 8'h00);
    rd(4'd9, rv); chk("R1 ctrl", rv, 8'h00);

    // R2 status layout sweep
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      mux_ch = i[3:0]; unipolar = i[4]; conv_busy = i[5];
      rd(4'd8, rv);
      chk("R2 status", rv, {i[5], i[4], 2'b00, i[3:0]});
    end
    rd(4'd5, rv); chk("R2 unmapped", rv, 8'h00);
    mux_ch = 0; unipolar = 0; conv_busy = 0;

    // R13 readback
    wr(4'd9, 8'h5B); rd(4'd9, rv); chk("R13 ctrl", rv, 8'h5B);
    wr(4'd11, 8'hFE); rd(4'd11, rv); chk("R13 mode", rv, 8'h02);
    wr(4'd11, 8'h00);

    // R6 R7 R8 R9 source sweep (interrupt enable set, R10)
    for (int ts = 0; ts < 4; ts++)
      for (int m = 0; m < 4; m++)
        for (int k = 1; k <= 3; k++) begin
          wr(4'd9, 8'h08 | 8'(ts));
          wr(4'd11, 8'(m));
          wr(4'd8, 8'h00);
          if (k == 2) half_cross(); else pulse(k);
          rd(4'd8, rv);
          chk($sformatf("R6/R7/R8/R9 ts=%0d mode=%0d ev=%0d", ts, m, k), rv[4],
              exp_src(ts, m & 1, m >> 1) == k);
          chk("R10 irq follows flag", irq, exp_src(ts, m & 1, m >> 1) == k);
        end
    wr(4'd11, 8'h00);

    // R7 held level does not re-set
    wr(4'd9, 8'h0A); wr(4'd8, 8'h00);
    @(negedge clk); fifo_count = 11'd600;
    @(negedge clk); @(negedge clk);
    wr(4'd8, 8'h00);
    repeat (4) @(negedge clk);
    rd(4'd8, rv); chk("R7 no rearm", rv[4], 1'b0);
    @(negedge clk); fifo_count = 11'd0;

    // R10 enable gating
    wr(4'd9, 8'h00); pulse(1);
    chk("R10 irq disabled", irq, 1'b0);
    rd(4'd8, rv); chk("R5 flag set while disabled", rv[4], 1'b1);
    wr(4'd9, 8'h08); chk("R10 irq enabled", irq, 1'b1);
    wr(4'd9, 8'h00); chk("R10 irq off again", irq, 1'b0);

    // R5 clear versus same-cycle set
    wr(4'd8, 8'h00); rd(4'd8, rv); chk("R5 cleared", rv[4], 1'b0);
    @(negedge clk); bus_addr = 4'd8; bus_wr = 1'b1; fifo_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; fifo_wr = 1'b0;
    rd(4'd8, rv); chk("R5 set wins", rv[4], 1'b1);
    wr(4'd3, 8'h00); rd(4'd8, rv); chk("R5 other write keeps", rv[4], 1'b1);

    // R3 R4 overrun
    @(negedge clk); fifo_full = 1'b1;
    @(negedge clk);
    rd(4'd8, rv); chk("R3 ovrn set", rv[5], 1'b1);
    wr(4'd8, 8'h00); wr(4'd9, 8'h00); wr(4'd3, 8'h00);
    rd(4'd8, rv); chk("R4 ovrn held", rv[5], 1'b1);
    wr(4'd2, 8'h00);
    repeat (3) @(negedge clk);
    rd(4'd8, rv); chk("R4 ovrn cleared, full held", rv[5], 1'b0);
    @(negedge clk); fifo_full = 1'b0;
    @(negedge clk); fifo_full = 1'b1;
    @(negedge clk); fifo_full = 1'b0;
    rd(4'd8, rv); chk("R3 ovrn re-set", rv[5], 1'b1);
    wr(4'd2, 8'h00);

    // R11 dout sweep, R12 ext flag
    for (int v = 0; v < 16; v++) begin
      wr(4'd3, {4'hA, v[3:0]});
      chk("R11 dout", dout, v[3:0]);
    end
    wr(4'd9, 8'h03); chk("R11 dout unaffected", dout, 4'hF);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    chk("R12 ext set", ext_trig_flag, 1'b1);
    wr(4'd8, 8'h00); chk("R12 ext held", ext_trig_flag, 1'b1);
    @(negedge clk); bus_addr = 4'd3; bus_wdata = 8'h05; bus_wr = 1'b1; ext_trig = 1'b1;
    @(negedge clk); bus_wr = 1'b0; ext_trig = 1'b0;
    chk("R11 ext set wins", ext_trig_flag, 1'b1);
    wr(4'd3, 8'h06);
    chk("R11 ext cleared", ext_trig_flag, 1'b0);
    chk("R11 dout value", dout, 4'h6);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule